// File: doc/BRIEF.md
# Module Clock Gate and Reset Register Bank

This block is a word-addressed register bank that turns peripheral module clocks on and off and holds peripheral modules in reset. It has two kinds of control register, clock-on registers and reset registers. Each carries sixteen control bits in its lower half-word. The upper half-word of every write is a per-bit mask: bit n+16 set lets bit n take the written value, and bit n+16 clear leaves bit n alone. Software can therefore change one module's clock or reset without first reading the register, and without racing another agent that changes a different bit.

Each control register has a monitor register at the same offset plus 0x180. A monitor reports the state that was actually applied: the gate enable, or the reset line. It reaches the bus side through a multi-flop synchronizer, so its latency is fixed. Reset release is held back by a slow reference clock. A module's reset line stays low until two rising edges of that clock, taken through a synchronizer, have been seen while the line was low. This guarantees at least one full reference period of reset, even when software asserts and releases with two back-to-back writes.

Top module: `modgate_bank`

## Requirements
- R1: A write to a control register changes exactly the bits n whose mask bit n+16 is 1. Bits whose mask bit is 0 keep their previous value.
- R2: A clock-on bit set to 1 drives its `clk_en_o` bit high from the write's clock edge onward. A clock-on bit set to 0 drives it low.
- R3: The clock monitor register at clock-on offset + 0x180 reads 1 in bit n once clock n is enabled. A read sampled on the third edge after the write edge returns the new value. A read sampled on the first or second edge after the write returns the old value.
- R4: A reset bit written to 0 with its mask set drives its `mod_rst_no` bit low from the edge after the write edge.
- R5: A reset bit written to 1 releases the module only after two synchronized rising edges of `ref_clk` have been seen while the line was low, so the line stays low for at least one `ref_clk` period. If that condition is already met, the line goes high on the edge after the write edge.
- R6: The reset monitor register at reset offset + 0x180 reads 0 in bit n while module n is held in reset and 1 once it is released. The new value is seen by a read sampled on the third edge after the line changes, and not by a read sampled on the second.
- R7: After the bank reset, all clock enables are 0, all module resets are asserted (low), and every control and monitor register reads 0.
- R8: A read of a control register returns the stored bits in [15:0] and 0 in [31:16]. Read data is registered: it appears on the cycle after the read and holds until the next read.
- R9: A read of an unmapped or misaligned address (address bits [1:0] not 00) returns 0. A write to such an address changes no register and no output.

Default map: clock-on registers at 0x000 and 0x004, reset registers at 0x100 and 0x104, clock monitors at 0x180 and 0x184, reset monitors at 0x280 and 0x284. `clk_en_o` and `mod_rst_no` bit 16*i+n belong to register i, bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and bank clock |
| rst_ni | input | 1 | Asynchronous active-low bank reset |
| ref_clk | input | 1 | Slow reference clock that sets the minimum reset length |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data: [31:16] mask, [15:0] value |
| bus_rdata | output | 32 | Registered read data |
| clk_en_o | output | 16*NUM_CLK_REGS | Module clock gate enables |
| mod_rst_no | output | 16*NUM_RST_REGS | Module resets, active low |

## Verification
Call the edge that samples a write T. Clock enables change at T. Reset lines fall at T+1, and a released reset line rises at T+1 once its reference condition holds. Clock monitors are visible to a read sampled at T+3, and reset monitors to a read sampled at T+4. The bench drives on falling edges and samples on the next falling edge. It reads monitors one edge before and exactly on the due edge, so both the old and the new value are checked. The minimum reset length is measured in bench cycles from the first low sample to the first high sample, and compared with the reference period.

// File: rtl/modgate_pkg.sv
`timescale 1ns/1ps
package modgate_pkg;

   localparam int unsigned HALF_W     = 16;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned MON_OFFSET = 32'h180;

   // new = value bits where mask set, old bits elsewhere
   function automatic logic [HALF_W-1:0] masked_merge(
      input logic [HALF_W-1:0] old_val,
      input logic [WORD_W-1:0] wword
   );
      logic [HALF_W-1:0] msk;
      msk = wword[WORD_W-1:HALF_W];
      return (old_val & ~msk) | (wword[HALF_W-1:0] & msk);
   endfunction

   function automatic bit spans_overlap(
      input int unsigned a_lo, input int unsigned a_len,
      input int unsigned b_lo, input int unsigned b_len
   );
      return (a_lo < b_lo + b_len) && (b_lo < a_lo + a_len);
   endfunction

endpackage

// File: rtl/modgate_sync.sv
`timescale 1ns/1ps
module modgate_sync #(
   parameter int unsigned W      = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stg[0] <= '0;
      else         stg[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_ni) begin
         if (!rst_ni) stg[s] <= '0;
         else         stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/modgate_mask_reg.sv
`timescale 1ns/1ps
module modgate_mask_reg
   import modgate_pkg::*;
#(
   parameter logic [HALF_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [HALF_W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)   q_o <= RESET_VAL;
      else if (wr_i) q_o <= masked_merge(q_o, wdata_i);
   end

endmodule

// File: rtl/modgate_rst_hold.sv
`timescale 1ns/1ps
module modgate_rst_hold #(
   parameter int unsigned W         = 16,
   parameter int unsigned MIN_TICKS = 2
) (
   input  logic         clk,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic [W-1:0] ctrl_i,
   output logic [W-1:0] rst_no
);

   localparam int unsigned CNT_W = $clog2(MIN_TICKS + 1);
   localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(MIN_TICKS);

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [CNT_W-1:0] ticks_q;

      always_ff @(posedge clk or negedge rst_ni) begin
         if (!rst_ni) begin
            ticks_q   <= '0;
            rst_no[b] <= 1'b0;
         end else if (rst_no[b]) begin
            // running: a clear control bit drops the line at once
            ticks_q   <= '0;
            rst_no[b] <= ctrl_i[b];
         end else begin
            if (tick_i && (ticks_q != CNT_DONE)) ticks_q <= ticks_q + 1'b1;
            rst_no[b] <= ctrl_i[b] && (ticks_q == CNT_DONE);
         end
      end
   end

endmodule

// File: rtl/modgate_bank.sv
`timescale 1ns/1ps
module modgate_bank
   import modgate_pkg::*;
#(
   parameter int unsigned NUM_CLK_REGS  = 2,
   parameter int unsigned NUM_RST_REGS  = 2,
   parameter int unsigned ADDR_W        = 10,
   parameter int unsigned CLK_BASE      = 32'h000,
   parameter int unsigned RST_BASE      = 32'h100,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned MIN_REF_TICKS = 2
) (
   input  logic                           clk,
   input  logic                           rst_ni,
   input  logic                           ref_clk,
   input  logic                           bus_en,
   input  logic                           bus_we,
   input  logic [ADDR_W-1:0]              bus_addr,
   input  logic [31:0]                    bus_wdata,
   output logic [31:0]                    bus_rdata,
   output logic [NUM_CLK_REGS*HALF_W-1:0] clk_en_o,
   output logic [NUM_RST_REGS*HALF_W-1:0] mod_rst_no
);

   localparam int unsigned CLK_BITS = NUM_CLK_REGS * HALF_W;
   localparam int unsigned RST_BITS = NUM_RST_REGS * HALF_W;
   localparam int unsigned CLK_SPAN = NUM_CLK_REGS * 4;
   localparam int unsigned RST_SPAN = NUM_RST_REGS * 4;
   localparam int unsigned CLK_MON  = CLK_BASE + MON_OFFSET;
   localparam int unsigned RST_MON  = RST_BASE + MON_OFFSET;
   localparam int unsigned ADDR_TOP = 1 << ADDR_W;

   // ---------------- elaboration checks ----------------
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("modgate_bank: SYNC_STAGES must be at least 2");
   end
   if (MIN_REF_TICKS < 1) begin : g_bad_ticks
      $error("modgate_bank: MIN_REF_TICKS must be at least 1");
   end
   if (NUM_CLK_REGS < 1 || NUM_RST_REGS < 1) begin : g_bad_count
      $error("modgate_bank: register counts must be at least 1");
   end
   if ((CLK_BASE % 4) != 0 || (RST_BASE % 4) != 0) begin : g_bad_align
      $error("modgate_bank: bases must be word aligned");
   end
   if (spans_overlap(CLK_BASE, CLK_SPAN, RST_BASE, RST_SPAN) ||
       spans_overlap(CLK_BASE, CLK_SPAN, CLK_MON,  CLK_SPAN) ||
       spans_overlap(CLK_BASE, CLK_SPAN, RST_MON,  RST_SPAN) ||
       spans_overlap(RST_BASE, RST_SPAN, CLK_MON,  CLK_SPAN) ||
       spans_overlap(RST_BASE, RST_SPAN, RST_MON,  RST_SPAN) ||
       spans_overlap(CLK_MON,  CLK_SPAN, RST_MON,  RST_SPAN)) begin : g_bad_map
      $error("modgate_bank: register regions overlap");
   end
   if (CLK_MON + CLK_SPAN > ADDR_TOP || RST_MON + RST_SPAN > ADDR_TOP) begin : g_bad_width
      $error("modgate_bank: ADDR_W too narrow for the map");
   end

   // ---------------- address decode ----------------
   logic [NUM_CLK_REGS-1:0] clk_hit, clkmon_hit;
   logic [NUM_RST_REGS-1:0] rst_hit, rstmon_hit;
   logic [31:0]             addr_w;

   assign addr_w = 32'(bus_addr);

   always_comb begin
      for (int i = 0; i < NUM_CLK_REGS; i++) begin
         clk_hit[i]    = bus_en && (addr_w == CLK_BASE + 4 * i);
         clkmon_hit[i] = bus_en && (addr_w == CLK_MON + 4 * i);
      end
      for (int i = 0; i < NUM_RST_REGS; i++) begin
         rst_hit[i]    = bus_en && (addr_w == RST_BASE + 4 * i);
         rstmon_hit[i] = bus_en && (addr_w == RST_MON + 4 * i);
      end
   end

   // ---------------- control registers ----------------
   logic [RST_BITS-1:0] rst_ctrl;

   for (genvar i = 0; i < NUM_CLK_REGS; i++) begin : g_clk_reg
      modgate_mask_reg #(.RESET_VAL('0)) u_reg (
         .clk     (clk),
         .rst_ni  (rst_ni),
         .wr_i    (clk_hit[i] && bus_we),
         .wdata_i (bus_wdata),
         .q_o     (clk_en_o[i*HALF_W +: HALF_W])
      );
   end

   for (genvar i = 0; i < NUM_RST_REGS; i++) begin : g_rst_reg
      modgate_mask_reg #(.RESET_VAL('0)) u_reg (
         .clk     (clk),
         .rst_ni  (rst_ni),
         .wr_i    (rst_hit[i] && bus_we),
         .wdata_i (bus_wdata),
         .q_o     (rst_ctrl[i*HALF_W +: HALF_W])
      );
   end

   // ---------------- reference clock edge ----------------
   logic ref_sync, ref_prev, ref_tick;

   modgate_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ref_sync (
      .clk    (clk),
      .rst_ni (rst_ni),
      .d_i    (ref_clk),
      .q_o    (ref_sync)
   );

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) ref_prev <= 1'b0;
      else         ref_prev <= ref_sync;
   end

   assign ref_tick = ref_sync && !ref_prev;

   // ---------------- reset hold-off ----------------
   modgate_rst_hold #(.W(RST_BITS), .MIN_TICKS(MIN_REF_TICKS)) u_hold (
      .clk    (clk),
      .rst_ni (rst_ni),
      .tick_i (ref_tick),
      .ctrl_i (rst_ctrl),
      .rst_no (mod_rst_no)
   );

   // ---------------- monitors ----------------
   logic [CLK_BITS-1:0] clk_mon;
   logic [RST_BITS-1:0] rst_mon;

   modgate_sync #(.W(CLK_BITS), .STAGES(SYNC_STAGES)) u_clk_mon (
      .clk    (clk),
      .rst_ni (rst_ni),
      .d_i    (clk_en_o),
      .q_o    (clk_mon)
   );

   modgate_sync #(.W(RST_BITS), .STAGES(SYNC_STAGES)) u_rst_mon (
      .clk    (clk),
      .rst_ni (rst_ni),
      .d_i    (mod_rst_no),
      .q_o    (rst_mon)
   );

   // ---------------- read path ----------------
   logic [HALF_W-1:0] rd_half;

   always_comb begin
      rd_half = '0;
      for (int i = 0; i < NUM_CLK_REGS; i++) begin
         if (clk_hit[i])    rd_half = rd_half | clk_en_o[i*HALF_W +: HALF_W];
         if (clkmon_hit[i]) rd_half = rd_half | clk_mon[i*HALF_W +: HALF_W];
      end
      for (int i = 0; i < NUM_RST_REGS; i++) begin
         if (rst_hit[i])    rd_half = rd_half | rst_ctrl[i*HALF_W +: HALF_W];
         if (rstmon_hit[i]) rd_half = rd_half | rst_mon[i*HALF_W +: HALF_W];
      end
   end

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)                bus_rdata <= '0;
      else if (bus_en && !bus_we) bus_rdata <= {{(WORD_W-HALF_W){1'b0}}, rd_half};
   end

endmodule

// File: rtl/modgate_bank_chk.sv
`timescale 1ns/1ps
module modgate_bank_chk #(
   parameter int unsigned NUM_CLK_REGS  = 2,
   parameter int unsigned NUM_RST_REGS  = 2,
   parameter int unsigned ADDR_W        = 10,
   parameter int unsigned CLK_BASE      = 32'h000,
   parameter int unsigned RST_BASE      = 32'h100,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned MIN_REF_TICKS = 2
) (
   input logic                     clk,
   input logic                     rst_ni,
   input logic                     ref_clk,
   input logic                     bus_en,
   input logic                     bus_we,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [31:0]              bus_wdata,
   input logic [31:0]              bus_rdata,
   input logic [NUM_CLK_REGS*16-1:0] clk_en_o,
   input logic [NUM_RST_REGS*16-1:0] mod_rst_no
);

   logic ref_prev;
   logic ref_rise;

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) ref_prev <= 1'b0;
      else         ref_prev <= ref_clk;
   end
   assign ref_rise = ref_clk && !ref_prev;

   // R1 / R2: clock-on writes merge under the mask
   for (genvar i = 0; i < NUM_CLK_REGS; i++) begin : g_clk
      p_masked_clk_r1: assert property (@(posedge clk) disable iff (!rst_ni)
         (bus_en && bus_we && (32'(bus_addr) == CLK_BASE + 4 * i)) |=>
         (clk_en_o[i*16 +: 16] ==
            (($past(clk_en_o[i*16 +: 16]) & ~$past(bus_wdata[31:16])) |
             ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16])))));
   end

   // R4: masked zero in a reset register drives the line low one edge later
   for (genvar i = 0; i < NUM_RST_REGS; i++) begin : g_rst
      p_assert_rst_r4: assert property (@(posedge clk) disable iff (!rst_ni)
         (bus_en && bus_we && (32'(bus_addr) == RST_BASE + 4 * i)) |=> ##1
         ((mod_rst_no[i*16 +: 16] &
           $past(bus_wdata[31:16] & ~bus_wdata[15:0], 2)) == 16'h0000));
   end

   // R5: a line only rises after ref_clk rose while it was low
   for (genvar j = 0; j < NUM_RST_REGS * 16; j++) begin : g_len
      logic [1:0] rises_q;
      always_ff @(posedge clk or negedge rst_ni) begin
         if (!rst_ni)                           rises_q <= '0;
         else if (mod_rst_no[j])                rises_q <= '0;
         else if (ref_rise && rises_q != 2'd3)  rises_q <= rises_q + 2'd1;
      end
      p_min_len_r5: assert property (@(posedge clk) disable iff (!rst_ni)
         $rose(mod_rst_no[j]) |-> (rises_q != 2'd0));
   end

   // R8: control reads have an empty upper half
   p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_ni)
      (bus_en && !bus_we && (32'(bus_addr) == CLK_BASE)) |=>
      (bus_rdata[31:16] == 16'h0000));

   // R9: misaligned reads return zero
   p_misaligned_r9: assert property (@(posedge clk) disable iff (!rst_ni)
      (bus_en && !bus_we && (bus_addr[1:0] != 2'b00)) |=> (bus_rdata == 32'h0));

endmodule

bind modgate_bank modgate_bank_chk #(
   .NUM_CLK_REGS  (NUM_CLK_REGS),
   .NUM_RST_REGS  (NUM_RST_REGS),
   .ADDR_W        (ADDR_W),
   .CLK_BASE      (CLK_BASE),
   .RST_BASE      (RST_BASE),
   .SYNC_STAGES   (SYNC_STAGES),
   .MIN_REF_TICKS (MIN_REF_TICKS)
) u_chk (.*);

// File: tb/modgate_bank_bench.sv
`timescale 1ns/1ps
module modgate_bank_bench;

   localparam logic [9:0] A_CLK0 = 10'h000;
   localparam logic [9:0] A_CLK1 = 10'h004;
   localparam logic [9:0] A_RST0 = 10'h100;
   localparam logic [9:0] A_RST1 = 10'h104;
   localparam logic [9:0] A_CMON0 = 10'h180;
   localparam logic [9:0] A_CMON1 = 10'h184;
   localparam logic [9:0] A_RMON0 = 10'h280;
   localparam logic [9:0] A_RMON1 = 10'h284;
   localparam int REF_PER = 40;   // bus cycles per ref_clk period

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        ref_clk = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] clk_en_o;
   logic [31:0] mod_rst_no;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   logic [15:0] clk_m [2];
   logic [15:0] rst_m [2];

   always #2 clk = ~clk;
   always #80 ref_clk = ~ref_clk;

   modgate_bank u_modgate_bank (
      .clk        (clk),
      .rst_ni     (rst_ni),
      .ref_clk    (ref_clk),
      .bus_en     (bus_en),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .clk_en_o   (clk_en_o),
      .mod_rst_no (mod_rst_no)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc == 200000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: act=%0d cycles exp=<200000", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w);
      return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
   endfunction

   // called at a falling edge; returns at the falling edge after the write edge
   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, output logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_en = 1'b0;
      d = bus_rdata;
   endtask

   task automatic model_wr(input logic [9:0] a, input logic [31:0] d);
      case (a)
         A_CLK0: clk_m[0] = merge(clk_m[0], d);
         A_CLK1: clk_m[1] = merge(clk_m[1], d);
         A_RST0: rst_m[0] = merge(rst_m[0], d);
         A_RST1: rst_m[1] = merge(rst_m[1], d);
         default: ;
      endcase
      wr(a, d);
   endtask

   initial begin
      logic [31:0] r;
      logic [31:0] snap;
      int t_low;
      void'($urandom(32'd20240611));
      clk_m[0] = '0; clk_m[1] = '0; rst_m[0] = '0; rst_m[1] = '0;

      repeat (5) @(negedge clk);
      chk("R7 clk_en in reset", clk_en_o, 32'h0);
      chk("R7 mod_rst in reset", mod_rst_no, 32'h0);
      rst_ni = 1'b1;
      @(negedge clk);
      foreach (A_LIST[k]) begin
         rd(A_LIST[k], r);
         chk("R7 register reads zero", r, 32'h0);
      end

      // clock enable and its monitor
      model_wr(A_CLK0, 32'h0001_0001);
      chk("R2 clock on", {16'h0, clk_en_o[15:0]}, 32'h1);
      rd(A_CMON0, r);
      chk("R3 monitor old at T+1", r, 32'h0);
      @(negedge clk);
      rd(A_CMON0, r);
      chk("R3 monitor new at T+3", r, 32'h1);
      model_wr(A_CLK0, 32'h00F0_FFFF);
      chk("R1 masked merge", {16'h0, clk_en_o[15:0]}, 32'h00F1);
      model_wr(A_CLK1, 32'h8000_8000);
      chk("R1 second register", {16'h0, clk_en_o[31:16]}, 32'h8000);
      model_wr(A_CLK0, 32'h0001_0000);
      chk("R2 clock off", {16'h0, clk_en_o[15:0]}, 32'h00F0);

      // reset release after long hold
      repeat (150) @(negedge clk);
      model_wr(A_RST0, 32'h0001_0001);
      chk("R5 not released at write edge", {31'h0, mod_rst_no[0]}, 32'h0);
      @(negedge clk);
      chk("R5 released one edge later", {31'h0, mod_rst_no[0]}, 32'h1);
      @(negedge clk);
      rd(A_RMON0, r);
      chk("R6 monitor old at line+2", r, 32'h0);
      rd(A_RMON0, r);
      chk("R6 monitor new at line+3", r, 32'h1);

      // assert then immediate release: minimum length
      model_wr(A_RST0, 32'h0001_0000);
      chk("R4 still high at write edge", {31'h0, mod_rst_no[0]}, 32'h1);
      @(negedge clk);
      chk("R4 low one edge later", {31'h0, mod_rst_no[0]}, 32'h0);
      t_low = cyc;
      model_wr(A_RST0, 32'h0001_0001);
      repeat (2) @(negedge clk);
      rd(A_RMON0, r);
      chk("R6 monitor reads held", r, 32'h0);
      for (int n = 0; n < 500 && mod_rst_no[0] == 1'b0; n++) @(negedge clk);
      chk("R5 low at least one ref period", {31'h0, (cyc - t_low) >= REF_PER}, 32'h1);
      chk("R5 released in bounded time", {31'h0, (cyc - t_low) <= 2 * REF_PER + 20}, 32'h1);

      // unmapped and misaligned
      snap = clk_en_o;
      wr(10'h040, 32'hFFFF_FFFF);
      wr(10'h102, 32'hFFFF_0000);
      wr(10'h3FC, 32'hFFFF_FFFF);
      chk("R9 outputs untouched", clk_en_o, snap);
      rd(10'h040, r);  chk("R9 unmapped read", r, 32'h0);
      rd(10'h002, r);  chk("R9 misaligned read", r, 32'h0);
      rd(A_RST0, r);   chk("R9 reset reg untouched", r, {16'h0, rst_m[0]});
      rd(A_RST1, r);   chk("R9 reset reg1 untouched", r, {16'h0, rst_m[1]});

      // constrained random masked writes
      for (int it = 0; it < 200; it++) begin
         logic [9:0]  a;
         logic [31:0] d;
         int sel;
         sel = $urandom_range(0, 3);
         a = (sel == 0) ? A_CLK0 : (sel == 1) ? A_CLK1 : (sel == 2) ? A_RST0 : A_RST1;
         d = $urandom;
         if ($urandom_range(0, 7) == 0) d[31:16] = 16'h0;
         model_wr(a, d);
         if (sel < 2)
            chk("R2 clk_en follows write", clk_en_o, {clk_m[1], clk_m[0]});
         rd(a, r);
         chk("R1 R8 control readback",
             r, {16'h0, (sel == 0) ? clk_m[0] : (sel == 1) ? clk_m[1] :
                        (sel == 2) ? rst_m[0] : rst_m[1]});
      end

      repeat (200) @(negedge clk);
      chk("R5 outputs match control", mod_rst_no, {rst_m[1], rst_m[0]});
      rd(A_CMON0, r); chk("R3 clock monitor 0", r, {16'h0, clk_m[0]});
      rd(A_CMON1, r); chk("R3 clock monitor 1", r, {16'h0, clk_m[1]});
      rd(A_RMON0, r); chk("R6 reset monitor 0", r, {16'h0, rst_m[0]});
      rd(A_RMON1, r); chk("R6 reset monitor 1", r, {16'h0, rst_m[1]});

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   localparam logic [9:0] A_LIST [8] = '{A_CLK0, A_CLK1, A_RST0, A_RST1,
                                         A_CMON0, A_CMON1, A_RMON0, A_RMON1};

endmodule